// File: doc/BRIEF.md
# Cascaded Integrator-Comb Decimator

This block lowers the sample rate of a signed, demodulated stream by an integer factor R. It uses a chain of N integrators that run at the input rate and N comb sections that run at the decimated rate. Each comb section has a differential delay of M decimated samples. The default build uses nine stages, R = 250 and M = 1. R does not need to be a power of two.

Input samples are taken on each rising clock edge at which `valid_i` is high. When `valid_i` is low the edge is idle, and the data lines are ignored. Every R accepted samples, the block emits one reduced sample together with a one-cycle strobe. Between strobes the output holds its last value.

Internally every stage carries the full word: the input width plus ceil(N·log2(R·M)) growth bits. The arithmetic is two's complement and wraps around, so the comb result is bit-exact. Only the final step narrows the word. It discards the low-order bits, rounds convergently (ties go to even) and saturates on overflow. The result is suited to measuring a DC amplitude after a follow-on filter, and no droop correction is applied.

Top module: `cic_decimator`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `valid_o` is 0 and `data_o` is 0. Reset also clears all integrator, comb and rate-count state, so a stream that starts after reset sees zero history.
- R2: `valid_o` pulses exactly once for every R accepted samples. A sample is accepted when `valid_i` is 1 at a rising edge. Edges with `valid_i` at 0 neither advance the count nor affect any result, whatever `data_i` carries.
- R3: Take the edge that accepts the R-th sample of a group. `valid_o` is high for exactly one cycle, starting right after the rising edge that comes 2·N edges after that accepting edge.
- R4: Before narrowing, each output equals the exact sum of the accepted input sequence passed through N cascaded moving sums, each R·M samples long. The sequence is taken as zero before reset. The sum is sampled at accepted sample indices R−1, 2R−1, and so on. It is held in IN_W + ceil(N·log2(R·M)) bits, which gives 88 bits for the default.
- R5: Narrowing drops D = IN_W + growth − OUT_W low bits. The result rounds to the nearest value. A remainder of exactly half rounds to the even neighbour, for example +0.5→0, +1.5→2, +2.5→2, −1.5→−2 and −2.5→−2.
- R6: If rounding carries the value above the largest signed OUT_W value, `data_o` saturates to 2^(OUT_W−1)−1.
- R7: `data_o` changes only in the cycle in which `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | IN_W | Signed input sample |
| valid_o | output | 1 | One-cycle strobe per decimated sample |
| data_o | output | OUT_W | Signed, rounded and saturated decimated sample |

## Verification
A result is due 2·N rising edges after the edge that accepts the last sample of its group. That is 18 edges for the default build and 4 for the second, small build (R = 4, M = 2, N = 2, 8-bit output).

For every expected output, the bench's reference model stores the edge number on which the output is due. At each falling edge it compares the strobe against that number, so a result that arrives early, late, missing or unrequested is reported against the timing or rate requirement.

Directed DC cases on the small build each drive 16 accepted samples, which fills the full 15-sample impulse response. They then wait 2·N + 2 falling edges before reading the output, and read it again five cycles later to confirm that it is held.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Smallest g with (rm)^stages <= 2^g, i.e. ceil(stages*log2(rm)).
  function automatic int growth_bits(int stages, int rm);
    logic [255:0] prod;
    int g;
    prod = 256'd1;
    for (int i = 0; i < stages; i++) prod = prod * 256'(rm);
    g = 0;
    while ((256'd1 << g) < prod) g++;
    return g;
  endfunction

endpackage

// File: rtl/cic_rate_ctr.sv
module cic_rate_ctr #(
  parameter int R = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic last_o
);
  localparam int CNT_W = (R > 1) ? $clog2(R) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(R - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = valid_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      if (cnt_q == CNT_MAX) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int W = 88
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic         last_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic         last_o,
  output logic [W-1:0] dat_o
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      vld_o  <= 1'b0;
      last_o <= 1'b0;
    end else begin
      vld_o  <= vld_i;
      last_o <= vld_i & last_i;
      if (vld_i) acc_q <= acc_q + dat_i; // wraps by design
    end
  end

  assign dat_o = acc_q;
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int W = 88,
  parameter int M = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  logic [W-1:0] dly_q [M];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      dat_o <= '0;
      for (int i = 0; i < M; i++) dly_q[i] <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        dat_o    <= dat_i - dly_q[M-1];
        dly_q[0] <= dat_i;
        for (int i = 1; i < M; i++) dly_q[i] <= dly_q[i-1];
      end
    end
  end
endmodule

// File: rtl/cic_round_sat.sv
module cic_round_sat #(
  parameter int W     = 88,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [W-1:0]     dat_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] dat_o
);
  localparam int D = W - OUT_W;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  logic [OUT_W-1:0] rnd_d;

  if (D == 0) begin : g_pass
    assign rnd_d = dat_i;
  end else begin : g_round
    logic [OUT_W-1:0] keep;
    logic             round_up;
    logic [OUT_W:0]   sum;
    assign keep = dat_i[W-1:D];
    if (D == 1) begin : g_d1
      assign round_up = dat_i[0] & keep[0];
    end else begin : g_dn
      assign round_up = dat_i[D-1] & ((|dat_i[D-2:0]) | keep[0]);
    end
    assign sum   = {keep[OUT_W-1], keep} + {{OUT_W{1'b0}}, round_up};
    // only an upward carry can leave the range
    assign rnd_d = (sum[OUT_W] != sum[OUT_W-1]) ? POS_MAX : sum[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) dat_o <= rnd_d;
    end
  end
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int N     = 9,
  parameter int R     = 250,
  parameter int M     = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);
  localparam int G = growth_bits(N, R * M);
  localparam int W = IN_W + G;

  logic         grp_last;
  logic [W-1:0] int_dat [N+1];
  logic [N:0]   int_vld;
  logic [N:0]   int_last;
  logic [W-1:0] cmb_dat [N+1];
  logic [N:0]   cmb_vld;
  logic [W-1:0] comb_data;
  logic         comb_vld;

  cic_rate_ctr #(.R(R)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .last_o (grp_last)
  );

  assign int_dat[0]  = {{G{data_i[IN_W-1]}}, data_i};
  assign int_vld[0]  = valid_i;
  assign int_last[0] = grp_last;

  for (genvar gi = 0; gi < N; gi++) begin : g_integ
    cic_integ #(.W(W)) u_integ (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (int_vld[gi]),
      .last_i(int_last[gi]),
      .dat_i (int_dat[gi]),
      .vld_o (int_vld[gi+1]),
      .last_o(int_last[gi+1]),
      .dat_o (int_dat[gi+1])
    );
  end

  // decimation: only the group-closing sample enters the combs
  assign cmb_dat[0] = int_dat[N];
  assign cmb_vld[0] = int_vld[N] & int_last[N];

  for (genvar gc = 0; gc < N; gc++) begin : g_comb
    cic_comb #(.W(W), .M(M)) u_comb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (cmb_vld[gc]),
      .dat_i (cmb_dat[gc]),
      .vld_o (cmb_vld[gc+1]),
      .dat_o (cmb_dat[gc+1])
    );
  end

  assign comb_data = cmb_dat[N];
  assign comb_vld  = cmb_vld[N];

  cic_round_sat #(.W(W), .OUT_W(OUT_W)) u_rnd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (comb_vld),
    .dat_i (comb_data),
    .vld_o (valid_o),
    .dat_o (data_o)
  );
endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
  parameter int OUT_W = 16,
  parameter int R     = 250,
  parameter int W     = 88
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] data_o,
  input logic [W-1:0]     full_dat,
  input logic             full_vld
);
  localparam int D = W - OUT_W;
  localparam logic signed [W+1:0] HALF =
    (D > 0) ? ((W+2)'(1) <<< ((D > 0) ? D - 1 : 0)) : '0;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [W+1:0] MAX_SCALED =
    ((W+2)'(1) <<< (W - 1)) - ((W+2)'(1) <<< D);

  int unsigned       grp_cnt;
  int unsigned       owed;
  logic [W-1:0]      full_q;
  logic signed [W+1:0] full_ext, recon, err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_cnt <= 0;
      owed    <= 0;
      full_q  <= '0;
    end else begin
      if (valid_i) grp_cnt <= (grp_cnt == R - 1) ? 0 : grp_cnt + 1;
      owed <= owed + ((valid_i && grp_cnt == R - 1) ? 1 : 0) - (valid_o ? 1 : 0);
      if (full_vld) full_q <= full_dat;
    end
  end

  assign full_ext = {{2{full_q[W-1]}}, full_q};
  assign recon    = {{(W+2-OUT_W){data_o[OUT_W-1]}}, data_o} <<< D;
  assign err      = full_ext - recon;

  AST_OUT_OWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> owed != 0); // R2
  AST_COMB_TO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_vld |=> valid_o); // R3
  AST_ROUND_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && data_o != POS_MAX |-> err <= HALF && err >= -HALF); // R5
  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && data_o == POS_MAX |-> full_ext >= MAX_SCALED - HALF); // R6
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R7
endmodule

bind cic_decimator cic_decimator_chk #(
  .OUT_W(OUT_W),
  .R    (R),
  .W    (W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .data_o  (data_o),
  .full_dat(comb_data),
  .full_vld(comb_vld)
);

// File: tb/cic_decimator_model.sv
module cic_decimator_model #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int N     = 9,
  parameter int R     = 250,
  parameter int M     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  input  logic             valid_o,
  input  logic [OUT_W-1:0] data_o,
  output int               n_chk,
  output int               n_fail
);
  typedef logic signed [127:0] w_t;

  function automatic int grow(int stages, int rm);
    logic [127:0] p;
    int g;
    p = 128'd1;
    for (int i = 0; i < stages; i++) p = p * 128'(rm);
    g = 0;
    while ((128'd1 << g) < p) g++;
    return g;
  endfunction

  localparam int RM = R * M;
  localparam int D  = IN_W + grow(N, RM) - OUT_W;

  function automatic logic [OUT_W-1:0] reduce(w_t v);
    w_t q, rem, half, mx, mn;
    q    = v >>> D;
    rem  = v - (q <<< D);
    half = w_t'(1) <<< (D - 1);
    if (rem > half || (rem == half && q[0])) q = q + 1;
    mx = (w_t'(1) <<< (OUT_W - 1)) - 1;
    mn = -(w_t'(1) <<< (OUT_W - 1));
    if (q > mx) q = mx;
    if (q < mn) q = mn;
    return q[OUT_W-1:0];
  endfunction

  w_t hist [N][RM];
  w_t box  [N];
  int ptr, grp, ecnt;
  int chk_c = 0;
  int fail_c = 0;
  logic [OUT_W-1:0] exp_q[$];
  int due_q[$];

  assign n_chk  = chk_c;
  assign n_fail = fail_c;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        box[k] = '0;
        for (int j = 0; j < RM; j++) hist[k][j] = '0;
      end
      ptr = 0; grp = 0; ecnt = 0;
      exp_q.delete(); due_q.delete();
    end else begin
      ecnt = ecnt + 1;
      if (valid_i) begin
        w_t inv;
        inv = w_t'($signed(data_i));
        for (int k = 0; k < N; k++) begin
          box[k] = box[k] + inv - hist[k][ptr];
          hist[k][ptr] = inv;
          inv = box[k];
        end
        ptr = (ptr == RM - 1) ? 0 : ptr + 1;
        if (grp == R - 1) begin
          grp = 0;
          exp_q.push_back(reduce(box[N-1]));
          due_q.push_back(ecnt + 2 * N);
        end else begin
          grp = grp + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          chk_c++; fail_c++;
          $display("FAIL R2: unrequested output %0d, expected none", $signed(data_o));
        end else begin
          logic [OUT_W-1:0] e;
          int d;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          chk_c++;
          if (data_o !== e) begin
            fail_c++;
            $display("FAIL R4/R5/R6: data_o %0d expected %0d", $signed(data_o), $signed(e));
          end
          chk_c++;
          if (d != ecnt) begin
            fail_c++;
            $display("FAIL R3: output at edge %0d expected edge %0d", ecnt, d);
          end
        end
      end else if (due_q.size() != 0 && due_q[0] <= ecnt) begin
        chk_c++; fail_c++;
        $display("FAIL R2: no output at edge %0d expected edge %0d", ecnt, due_q[0]);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
      end
    end
  end
endmodule

// File: tb/cic_decimator_bench.sv
module cic_decimator_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        b_v = 1'b0;
  logic [15:0] b_x = '0;
  logic        b_vo;
  logic [15:0] b_do;
  logic        s_v = 1'b0;
  logic [15:0] s_x = '0;
  logic        s_vo;
  logic [7:0]  s_do;

  int chk = 0;
  int fails = 0;
  int mb_chk, mb_fail, ms_chk, ms_fail;

  cic_decimator u_cic_decimator (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(b_v), .data_i(b_x),
    .valid_o(b_vo), .data_o(b_do)
  );

  cic_decimator #(.IN_W(16), .OUT_W(8), .N(2), .R(4), .M(2)) u_cic_decimator_small (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(s_v), .data_i(s_x),
    .valid_o(s_vo), .data_o(s_do)
  );

  cic_decimator_model m_big (
    .clk(clk), .rst_n(rst_n), .valid_i(b_v), .data_i(b_x),
    .valid_o(b_vo), .data_o(b_do), .n_chk(mb_chk), .n_fail(mb_fail)
  );

  cic_decimator_model #(.IN_W(16), .OUT_W(8), .N(2), .R(4), .M(2)) m_small (
    .clk(clk), .rst_n(rst_n), .valid_i(s_v), .data_i(s_x),
    .valid_o(s_vo), .data_o(s_do), .n_chk(ms_chk), .n_fail(ms_fail)
  );

  task automatic check(bit ok, string req, longint act, longint expv);
    chk++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic report();
    int total, bad;
    total = chk + mb_chk + ms_chk;
    bad   = fails + mb_fail + ms_fail;
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  endtask

  task automatic reset_checks();
    check(b_vo == 1'b0, "R1", b_vo, 0);
    check(b_do == '0, "R1", $signed(b_do), 0);
    check(s_vo == 1'b0, "R1", s_vo, 0);
    check(s_do == '0, "R1", $signed(s_do), 0);
  endtask

  // small build: output = round_even(x/256) for settled DC input x
  task automatic small_dc(int x, int expv, string req);
    logic [7:0] first;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); s_v = 1'b1; s_x = 16'(x);
    end
    @(negedge clk); s_v = 1'b0; s_x = 16'h5a5a;
    repeat (6) @(negedge clk);
    check(int'($signed(s_do)) == expv, req, $signed(s_do), expv);
    first = s_do;
    repeat (5) begin
      @(negedge clk); s_x = 16'($urandom);
    end
    check(s_do == first, "R7", $signed(s_do), $signed(first));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; chk++;
    $display("FAIL R3: watchdog expired, got no end expected end");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks();

    // R2 R4: random data with idle gaps that carry garbage
    for (int i = 0; i < 7000; i++) begin
      @(negedge clk);
      b_v = ($urandom % 4) != 0;
      b_x = 16'($urandom);
    end
    // R4: full-scale DC both signs, then alternating extremes
    for (int i = 0; i < 2600; i++) begin
      @(negedge clk); b_v = 1'b1; b_x = 16'h7fff;
    end
    for (int i = 0; i < 2600; i++) begin
      @(negedge clk); b_v = 1'b1; b_x = 16'h8000;
    end
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); b_v = 1'b1; b_x = i[0] ? 16'h7fff : 16'h8000;
    end
    @(negedge clk); b_v = 1'b0;
    repeat (30) @(negedge clk);

    // small build random, R2 R4 with M=2
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      s_v = ($urandom % 3) != 0;
      s_x = 16'($urandom);
    end
    // mid-stream reset, R1
    @(negedge clk); rst_n = 1'b0; s_v = 1'b0;
    @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      s_v = ($urandom % 2) != 0;
      s_x = 16'($urandom);
    end
    @(negedge clk); s_v = 1'b0;
    repeat (10) @(negedge clk);

    small_dc(128, 0, "R5");
    small_dc(384, 2, "R5");
    small_dc(640, 2, "R5");
    small_dc(-384, -2, "R5");
    small_dc(-640, -2, "R5");
    small_dc(200, 1, "R5");
    small_dc(32767, 127, "R6");
    small_dc(-32768, -128, "R6");

    repeat (40) @(negedge clk);
    report();
  end
endmodule